// File: doc/BRIEF.md
# Memory Load/Store Ordering Buffer with Address Disambiguation

This block sits between effective-address generation and a single data memory port. Memory operations enter one per cycle, in program order, with their address already computed. Stores go into a circular store queue. Loads go into a load buffer, and each load keeps a mask of the stores that were older than it when it arrived. A store's data may arrive with it, or later from the shared result bus, matched by producer tag.

Each cycle, every load compares its address against its older stores. A load with no alias issues a memory read ahead of those stores. A load with aliases takes the data of the youngest aliasing store through a forwarding path that does not use the memory port. If that store has no data yet, the load waits. Stores drain in program order. A store holds back while any older load to the same address is still pending.

Completed loads appear on a registered result output, tagged with the load's destination tag.

Top module: `mem_disambig_buf`

## Requirements
- R1: After reset, `ld_valid_o` and `mem_req_o` are 0, and both `st_ready_o` and `ld_ready_o` are 1.
- R2: A store (`alloc_store_i`=1) requests a memory write (`mem_we_o`=1) only once its data is present. Data is present when `alloc_data_ok_i` is 1 at allocation, or when `cdb_valid_i` is 1 with `cdb_tag_i` equal to the store's `alloc_tag_i`. That capture may happen in the allocation cycle itself. Bus traffic with other tags is ignored.
- R3: A load (`alloc_store_i`=0) whose address matches none of its older pending stores issues a memory read (`mem_we_o`=0) even while those stores are still waiting for data. Its result is the memory data.
- R4: A load whose address matches one or more older pending stores returns the data of the youngest of them, and issues no memory read.
- R5: A load whose youngest matching older store has no data yet waits without a result or a memory request. It completes in the cycle after the store captures its data.
- R6: Stores write memory in program order, at most one per cycle. A write request held back by `mem_gnt_i`=0 keeps the same address and data.
- R7: While an older load to the same address is still pending, the oldest store makes no write request. The load's read goes to memory first.
- R8: A store ready at the head of the queue takes the memory port ahead of a pending load read to a different address.
- R9: `st_ready_o` is 0 while NUM_ST stores are pending. `ld_ready_o` is 0 while NUM_LD loads are pending.
- R10: At most one load completes per cycle, and a forwarding load is preferred over a reading one. `ld_valid_o` pulses for one cycle, in the cycle after completion, with the load's tag and its data. For a read, the data is `mem_rdata_i` from the granted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | New memory operation present |
| alloc_store_i | input | 1 | 1 = store, 0 = load |
| alloc_addr_i | input | ADDR_W | Effective address |
| alloc_tag_i | input | TAG_W | Load: destination tag; store: producer tag of its data |
| alloc_data_i | input | DATA_W | Store data when already known |
| alloc_data_ok_i | input | 1 | Store data in `alloc_data_i` is valid |
| st_ready_o | output | 1 | Store queue can accept |
| ld_ready_o | output | 1 | Load buffer can accept |
| cdb_valid_i | input | 1 | Result bus carries a value |
| cdb_tag_i | input | TAG_W | Result bus tag |
| cdb_data_i | input | DATA_W | Result bus value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | DATA_W | Read data for an accepted read, same cycle |
| ld_valid_o | output | 1 | Load result valid |
| ld_tag_o | output | TAG_W | Load result tag |
| ld_data_o | output | DATA_W | Load result data |

## Verification
A load completing through forwarding and a store draining to memory can land in the same cycle, because they use separate read paths. The bench provokes this by parking a data-less store with four aliasing loads behind it, then releasing the store's tag on the result bus.

The scoreboard expects, from that one cycle on, the store's write and the first load's forwarded value. After that it expects the remaining loads to read the newly written value from memory, one per cycle. Any read issued for the forwarded load, or any misordering of write and result, shows up as a mismatch in the ordered operation and result queues.

// File: rtl/mem_disambig_pkg.sv
package mem_disambig_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_WRITE = 2'd1,
    PORT_READ  = 2'd2
  } port_op_e;
endpackage

// File: rtl/mem_disambig_stq.sv
// Circular store queue: in-order allocation and drain, data capture from result bus.
module mem_disambig_stq #(
  parameter int NS = 4,
  parameter int NL = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_en_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [DW-1:0] alloc_data_i,
  input  logic          alloc_data_ok_i,
  input  logic [TW-1:0] alloc_tag_i,
  input  logic [NL-1:0] alloc_lmask_i,
  input  logic          cdb_valid_i,
  input  logic [TW-1:0] cdb_tag_i,
  input  logic [DW-1:0] cdb_data_i,
  input  logic          drain_i,
  input  logic [NL-1:0] ld_clr_i,
  output logic [NS-1:0] valid_o,
  output logic [NS-1:0] dok_o,
  output logic [AW-1:0] addr_o [NS],
  output logic [DW-1:0] data_o [NS],
  output logic [IW-1:0] head_o,
  output logic [NL-1:0] head_lmask_o,
  output logic          full_o
);
  logic [NS-1:0] valid_q, dok_q;
  logic [AW-1:0] addr_q  [NS];
  logic [DW-1:0] data_q  [NS];
  logic [TW-1:0] qtag_q  [NS];
  logic [NL-1:0] lmask_q [NS];
  logic [IW-1:0] head_q, tail_q;
  logic          alloc_snoop;

  assign alloc_snoop = cdb_valid_i && (cdb_tag_i == alloc_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dok_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      for (int i = 0; i < NS; i++) begin
        addr_q[i]  <= '0;
        data_q[i]  <= '0;
        qtag_q[i]  <= '0;
        lmask_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (valid_q[i] && !dok_q[i] && cdb_valid_i && cdb_tag_i == qtag_q[i]) begin
          dok_q[i]  <= 1'b1;
          data_q[i] <= cdb_data_i;
        end
        lmask_q[i] <= lmask_q[i] & ~ld_clr_i;
      end
      if (drain_i) begin
        valid_q[head_q] <= 1'b0;
        head_q          <= head_q + IW'(1);
      end
      if (alloc_en_i) begin
        valid_q[tail_q] <= 1'b1;
        addr_q[tail_q]  <= alloc_addr_i;
        qtag_q[tail_q]  <= alloc_tag_i;
        lmask_q[tail_q] <= alloc_lmask_i;
        dok_q[tail_q]   <= alloc_data_ok_i | alloc_snoop;
        data_q[tail_q]  <= alloc_data_ok_i ? alloc_data_i : cdb_data_i;
        tail_q          <= tail_q + IW'(1);
      end
    end
  end

  assign valid_o      = valid_q;
  assign dok_o        = dok_q;
  assign addr_o       = addr_q;
  assign data_o       = data_q;
  assign head_o       = head_q;
  assign head_lmask_o = lmask_q[head_q];
  assign full_o       = &valid_q;
endmodule

// File: rtl/mem_disambig_ldb.sv
// Load buffer: per-entry older-store mask, associative compare, youngest-match pick.
module mem_disambig_ldb #(
  parameter int NL = 4,
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int TW = 4,
  localparam int LIW = $clog2(NL),
  localparam int SIW = $clog2(NS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           alloc_en_i,
  input  logic [AW-1:0]  alloc_addr_i,
  input  logic [TW-1:0]  alloc_tag_i,
  input  logic [NS-1:0]  alloc_smask_i,
  input  logic           done_i,
  input  logic [LIW-1:0] done_idx_i,
  input  logic [NS-1:0]  st_clr_i,
  input  logic [NS-1:0]  sq_valid_i,
  input  logic [NS-1:0]  sq_dok_i,
  input  logic [AW-1:0]  sq_addr_i [NS],
  input  logic [DW-1:0]  sq_data_i [NS],
  input  logic [SIW-1:0] sq_head_i,
  output logic [NL-1:0]  valid_o,
  output logic [AW-1:0]  addr_o [NL],
  output logic [TW-1:0]  tag_o [NL],
  output logic           full_o,
  output logic [NL-1:0]  fwd_rdy_o,
  output logic [NL-1:0]  byp_rdy_o,
  output logic [DW-1:0]  fwd_data_o [NL]
);
  logic [NL-1:0]  valid_q;
  logic [AW-1:0]  addr_q  [NL];
  logic [TW-1:0]  tag_q   [NL];
  logic [NS-1:0]  smask_q [NL];
  logic [LIW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = LIW'(i);
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_cmp
    logic [NS-1:0]  hit;
    logic [SIW-1:0] yng;
    logic           any;
    always_comb begin
      for (int s = 0; s < NS; s++) begin
        hit[s] = smask_q[l][s] && sq_valid_i[s] && (sq_addr_i[s] == addr_q[l]);
      end
      any = 1'b0;
      yng = '0;
      // walk oldest to youngest; last hit wins
      for (int k = 0; k < NS; k++) begin
        if (hit[sq_head_i + SIW'(k)]) begin
          any = 1'b1;
          yng = sq_head_i + SIW'(k);
        end
      end
      fwd_rdy_o[l]  = valid_q[l] && any && sq_dok_i[yng];
      byp_rdy_o[l]  = valid_q[l] && !any;
      fwd_data_o[l] = sq_data_i[yng];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NL; i++) begin
        addr_q[i]  <= '0;
        tag_q[i]   <= '0;
        smask_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NL; i++) smask_q[i] <= smask_q[i] & ~st_clr_i;
      if (done_i) valid_q[done_idx_i] <= 1'b0;
      if (alloc_en_i) begin
        valid_q[free_idx] <= 1'b1;
        addr_q[free_idx]  <= alloc_addr_i;
        tag_q[free_idx]   <= alloc_tag_i;
        smask_q[free_idx] <= alloc_smask_i & ~st_clr_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign tag_o   = tag_q;
  assign full_o  = &valid_q;
endmodule

// File: rtl/mem_disambig_buf.sv
// NUM_LD and NUM_ST must be powers of two, at least 2.
module mem_disambig_buf
  import mem_disambig_pkg::*;
#(
  parameter int NUM_LD = 4,
  parameter int NUM_ST = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic              alloc_store_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic              alloc_data_ok_i,
  output logic              st_ready_o,
  output logic              ld_ready_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [TAG_W-1:0]  ld_tag_o,
  output logic [DATA_W-1:0] ld_data_o
);
  localparam int LIW = $clog2(NUM_LD);
  localparam int SIW = $clog2(NUM_ST);

  logic [NUM_ST-1:0] sq_valid, sq_dok, st_clr, alloc_smask;
  logic [ADDR_W-1:0] sq_addr [NUM_ST];
  logic [DATA_W-1:0] sq_data [NUM_ST];
  logic [SIW-1:0]    sq_head;
  logic [NUM_LD-1:0] sq_head_lmask;
  logic              sq_full;

  logic [NUM_LD-1:0] lb_valid, fwd_rdy, byp_rdy, ld_clr, alloc_lmask;
  logic [ADDR_W-1:0] lb_addr [NUM_LD];
  logic [TAG_W-1:0]  lb_tag [NUM_LD];
  logic [DATA_W-1:0] fwd_data [NUM_LD];
  logic              lb_full;

  logic              st_alloc, ld_alloc, war_hit, head_ready, st_drain;
  logic              fwd_any, rd_any, ld_done;
  logic [LIW-1:0]    fwd_sel, rd_sel, done_idx;
  port_op_e          port_op;

  assign st_alloc = alloc_valid_i && alloc_store_i && !sq_full;
  assign ld_alloc = alloc_valid_i && !alloc_store_i && !lb_full;

  // older pending load aliasing the head store blocks its drain
  always_comb begin
    war_hit = 1'b0;
    for (int l = 0; l < NUM_LD; l++) begin
      if (sq_head_lmask[l] && lb_valid[l] && lb_addr[l] == sq_addr[sq_head]) war_hit = 1'b1;
    end
  end
  assign head_ready = sq_valid[sq_head] && sq_dok[sq_head] && !war_hit;

  always_comb begin
    fwd_any = 1'b0;
    rd_any  = 1'b0;
    fwd_sel = '0;
    rd_sel  = '0;
    for (int i = NUM_LD - 1; i >= 0; i--) begin
      if (fwd_rdy[i]) begin fwd_any = 1'b1; fwd_sel = LIW'(i); end
      if (byp_rdy[i]) begin rd_any  = 1'b1; rd_sel  = LIW'(i); end
    end
  end

  always_comb begin
    if (head_ready)           port_op = PORT_WRITE;
    else if (rd_any && !fwd_any) port_op = PORT_READ;
    else                      port_op = PORT_IDLE;
  end

  assign mem_req_o   = (port_op != PORT_IDLE);
  assign mem_we_o    = (port_op == PORT_WRITE);
  assign mem_addr_o  = (port_op == PORT_WRITE) ? sq_addr[sq_head] : lb_addr[rd_sel];
  assign mem_wdata_o = sq_data[sq_head];

  assign st_drain = head_ready && mem_gnt_i;
  assign ld_done  = fwd_any || (port_op == PORT_READ && mem_gnt_i);
  assign done_idx = fwd_any ? fwd_sel : rd_sel;

  always_comb begin
    st_clr = '0;
    ld_clr = '0;
    if (st_drain) st_clr[sq_head] = 1'b1;
    if (ld_done)  ld_clr[done_idx] = 1'b1;
  end
  assign alloc_smask = sq_valid & ~st_clr;
  assign alloc_lmask = lb_valid & ~ld_clr;

  mem_disambig_stq #(
    .NS(NUM_ST), .NL(NUM_LD), .AW(ADDR_W), .DW(DATA_W), .TW(TAG_W)
  ) stq_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .alloc_en_i     (st_alloc),
    .alloc_addr_i   (alloc_addr_i),
    .alloc_data_i   (alloc_data_i),
    .alloc_data_ok_i(alloc_data_ok_i),
    .alloc_tag_i    (alloc_tag_i),
    .alloc_lmask_i  (alloc_lmask),
    .cdb_valid_i    (cdb_valid_i),
    .cdb_tag_i      (cdb_tag_i),
    .cdb_data_i     (cdb_data_i),
    .drain_i        (st_drain),
    .ld_clr_i       (ld_clr),
    .valid_o        (sq_valid),
    .dok_o          (sq_dok),
    .addr_o         (sq_addr),
    .data_o         (sq_data),
    .head_o         (sq_head),
    .head_lmask_o   (sq_head_lmask),
    .full_o         (sq_full)
  );

  mem_disambig_ldb #(
    .NL(NUM_LD), .NS(NUM_ST), .AW(ADDR_W), .DW(DATA_W), .TW(TAG_W)
  ) ldb_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (ld_alloc),
    .alloc_addr_i (alloc_addr_i),
    .alloc_tag_i  (alloc_tag_i),
    .alloc_smask_i(alloc_smask),
    .done_i       (ld_done),
    .done_idx_i   (done_idx),
    .st_clr_i     (st_clr),
    .sq_valid_i   (sq_valid),
    .sq_dok_i     (sq_dok),
    .sq_addr_i    (sq_addr),
    .sq_data_i    (sq_data),
    .sq_head_i    (sq_head),
    .valid_o      (lb_valid),
    .addr_o       (lb_addr),
    .tag_o        (lb_tag),
    .full_o       (lb_full),
    .fwd_rdy_o    (fwd_rdy),
    .byp_rdy_o    (byp_rdy),
    .fwd_data_o   (fwd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_tag_o   <= '0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= ld_done;
      if (ld_done) begin
        ld_tag_o  <= lb_tag[done_idx];
        ld_data_o <= fwd_any ? fwd_data[fwd_sel] : mem_rdata_i;
      end
    end
  end

  assign st_ready_o = !sq_full;
  assign ld_ready_o = !lb_full;
endmodule

// File: rtl/mem_disambig_chk.sv
module mem_disambig_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_valid_i,
  input logic              alloc_store_i,
  input logic              st_ready_o,
  input logic              ld_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              ld_valid_o
);
  // R1
  rst_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (!ld_valid_o && !mem_req_o && st_ready_o && ld_ready_o));

  // R6
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_gnt_i) |=>
      (mem_req_o && mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R9
  st_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_ready_o && !(mem_req_o && mem_we_o && mem_gnt_i)) |=> !st_ready_o);

  // R9
  ld_full_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ld_ready_o) |-> $past(alloc_valid_i && !alloc_store_i));

  // R10
  ld_free_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_ready_o) |-> ld_valid_o);
endmodule

bind mem_disambig_buf mem_disambig_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/mem_disambig_buf_tb_top.sv
module mem_disambig_buf_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0, alloc_store = 1'b0, alloc_data_ok = 1'b0;
  logic [15:0] alloc_addr = '0;
  logic [3:0]  alloc_tag = '0;
  logic [31:0] alloc_data = '0;
  logic        st_ready, ld_ready;
  logic        cdb_valid = 1'b0;
  logic [3:0]  cdb_tag = '0;
  logic [31:0] cdb_data = '0;
  logic        mem_req, mem_we, mem_gnt = 1'b1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        ld_valid;
  logic [3:0]  ld_tag;
  logic [31:0] ld_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { bit we; logic [15:0] addr; logic [31:0] data; string req; } op_t;
  typedef struct { logic [3:0] tag; logic [31:0] data; string req; } res_t;
  op_t  op_q[$];
  res_t res_q[$];

  logic [31:0] mem_arr [256];
  logic [31:0] gold    [256];

  always #(CLK_P/2) clk = ~clk;

  mem_disambig_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_store_i(alloc_store), .alloc_addr_i(alloc_addr),
    .alloc_tag_i(alloc_tag), .alloc_data_i(alloc_data), .alloc_data_ok_i(alloc_data_ok),
    .st_ready_o(st_ready), .ld_ready_o(ld_ready),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .ld_valid_o(ld_valid), .ld_tag_o(ld_tag), .ld_data_o(ld_data)
  );

  // memory model
  assign mem_rdata = mem_arr[mem_addr[7:0]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= 32'h1000_0000 + 32'(i * 7);
    end else if (mem_req && mem_we && mem_gnt) begin
      mem_arr[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic exp_wr(input logic [15:0] a, input logic [31:0] d, input string req);
    op_t o;
    o.we = 1'b1; o.addr = a; o.data = d; o.req = req;
    op_q.push_back(o);
    gold[a[7:0]] = d;
  endtask

  task automatic exp_rd(input logic [15:0] a, input string req);
    op_t o;
    o.we = 1'b0; o.addr = a; o.data = '0; o.req = req;
    op_q.push_back(o);
  endtask

  task automatic exp_res(input logic [3:0] t, input logic [31:0] d, input string req);
    res_t r;
    r.tag = t; r.data = d; r.req = req;
    res_q.push_back(r);
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req && mem_gnt) begin
        if (op_q.size() == 0) begin
          chk(1'b0, "R3/R4", "unexpected memory op", {mem_we, mem_addr}, 64'h0);
        end else begin
          op_t e;
          e = op_q.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
              e.req, "memory op {we,addr,wdata}", {15'h0, mem_we, mem_addr, mem_wdata},
              {15'h0, e.we, e.addr, e.data});
        end
      end
      if (ld_valid) begin
        if (res_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected load result", {28'h0, ld_tag, ld_data}, 64'h0);
        end else begin
          res_t r;
          r = res_q.pop_front();
          chk(ld_tag == r.tag && ld_data == r.data, r.req, "load result {tag,data}",
              {28'h0, ld_tag, ld_data}, {28'h0, r.tag, r.data});
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input bit st, input logic [15:0] a, input logic [3:0] t,
                     input logic [31:0] d, input bit ok);
    @(posedge clk); #1;
    alloc_valid = 1'b1; alloc_store = st; alloc_addr = a; alloc_tag = t;
    alloc_data = d; alloc_data_ok = ok;
    @(posedge clk); #1;
    alloc_valid = 1'b0; alloc_data_ok = 1'b0;
  endtask

  task automatic bus(input logic [3:0] t, input logic [31:0] d);
    @(posedge clk); #1;
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    @(posedge clk); #1;
    cdb_valid = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) gold[i] = 32'h1000_0000 + 32'(i * 7);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk(!ld_valid, "R1", "ld_valid_o after reset", 64'(ld_valid), 0);
    chk(!mem_req, "R1", "mem_req_o after reset", 64'(mem_req), 0);
    chk(st_ready && ld_ready, "R1", "readies after reset", {62'h0, st_ready, ld_ready}, 64'h3);

    // R6: in-order drain of ready stores
    exp_wr(16'h0004, 32'hA1, "R6");
    exp_wr(16'h0008, 32'hA2, "R6");
    exp_wr(16'h000C, 32'hA3, "R6");
    put(1, 16'h0004, 4'd0, 32'hA1, 1);
    put(1, 16'h0008, 4'd0, 32'hA2, 1);
    put(1, 16'h000C, 4'd0, 32'hA3, 1);
    cyc(4);

    // R2: store waits for its data tag; other tags ignored
    put(1, 16'h0040, 4'd3, 32'h0, 0);
    cyc(4);
    chk(!mem_req, "R2", "store without data requests", 64'(mem_req), 0);
    bus(4'd7, 32'hDEAD_0007);
    cyc(2);
    chk(!mem_req, "R2", "store after foreign tag requests", 64'(mem_req), 0);
    exp_wr(16'h0040, 32'hC0DE_0003, "R2");
    bus(4'd3, 32'hC0DE_0003);
    cyc(4);

    // R2: capture in the allocation cycle itself
    exp_wr(16'h0044, 32'h5A5A_0002, "R2");
    @(posedge clk); #1;
    alloc_valid = 1'b1; alloc_store = 1'b1; alloc_addr = 16'h0044; alloc_tag = 4'd2;
    alloc_data_ok = 1'b0; cdb_valid = 1'b1; cdb_tag = 4'd2; cdb_data = 32'h5A5A_0002;
    @(posedge clk); #1;
    alloc_valid = 1'b0; cdb_valid = 1'b0;
    cyc(4);

    // R3: load bypasses a non-aliasing, data-less store
    put(1, 16'h0050, 4'd4, 32'h0, 0);
    exp_rd(16'h0060, "R3");
    exp_res(4'd1, gold[8'h60], "R3");
    put(0, 16'h0060, 4'd1, 32'h0, 0);
    cyc(4);
    chk(op_q.size() == 0 && res_q.size() == 0, "R3", "bypass load done before store",
        64'(op_q.size() + res_q.size()), 0);
    exp_wr(16'h0050, 32'h0000_5050, "R3");
    bus(4'd4, 32'h0000_5050);
    cyc(4);

    // R4 + R9: youngest aliasing store forwards, queue full
    put(1, 16'h0010, 4'd5, 32'h0, 0);
    put(1, 16'h0070, 4'd0, 32'hD1, 1);
    put(1, 16'h0070, 4'd0, 32'hD2, 1);
    put(1, 16'h0080, 4'd0, 32'hD3, 1);
    cyc(1);
    chk(!st_ready, "R9", "st_ready_o with full store queue", 64'(st_ready), 0);
    exp_res(4'd2, 32'hD2, "R4");
    put(0, 16'h0070, 4'd2, 32'h0, 0);
    cyc(4);
    chk(res_q.size() == 0, "R4", "forwarded load result pending", 64'(res_q.size()), 0);
    exp_wr(16'h0010, 32'hD0, "R6");
    exp_wr(16'h0070, 32'hD1, "R6");
    exp_wr(16'h0070, 32'hD2, "R6");
    exp_wr(16'h0080, 32'hD3, "R6");
    bus(4'd5, 32'hD0);
    cyc(6);

    // R5 + R9 + R10: loads wait on data-less store, forward and drain together
    put(1, 16'h0090, 4'd6, 32'h0, 0);
    for (int i = 0; i < 4; i++) put(0, 16'h0090, 4'(8 + i), 32'h0, 0);
    cyc(1);
    chk(!ld_ready, "R9", "ld_ready_o with full load buffer", 64'(ld_ready), 0);
    cyc(3);
    chk(!ld_valid && !mem_req, "R5", "waiting loads produce activity",
        {62'h0, ld_valid, mem_req}, 0);
    exp_wr(16'h0090, 32'h9999_0006, "R5");
    exp_rd(16'h0090, "R10");
    exp_rd(16'h0090, "R10");
    exp_rd(16'h0090, "R10");
    for (int i = 0; i < 4; i++) exp_res(4'(8 + i), 32'h9999_0006, "R5");
    bus(4'd6, 32'h9999_0006);
    cyc(8);

    // R7: store waits for an older aliasing load stalled on the port
    mem_gnt = 1'b0;
    put(0, 16'h00A0, 4'd4, 32'h0, 0);
    put(1, 16'h00A0, 4'd0, 32'hAAAA_0001, 1);
    cyc(2);
    chk(mem_req && !mem_we && mem_addr == 16'h00A0, "R7", "port request {req,we,addr}",
        {46'h0, mem_req, mem_we, mem_addr}, {46'h0, 2'b10, 16'h00A0});
    exp_rd(16'h00A0, "R7");
    exp_res(4'd4, gold[8'hA0], "R7");
    exp_wr(16'h00A0, 32'hAAAA_0001, "R7");
    @(posedge clk); #1;
    mem_gnt = 1'b1;
    cyc(5);

    // R8: non-aliasing ready store takes the port ahead of a load read
    mem_gnt = 1'b0;
    put(0, 16'h00B0, 4'd5, 32'h0, 0);
    put(1, 16'h00C0, 4'd0, 32'hCCCC_0002, 1);
    cyc(2);
    chk(mem_req && mem_we && mem_addr == 16'h00C0, "R8", "port request {req,we,addr}",
        {46'h0, mem_req, mem_we, mem_addr}, {46'h0, 2'b11, 16'h00C0});
    exp_wr(16'h00C0, 32'hCCCC_0002, "R8");
    exp_rd(16'h00B0, "R8");
    exp_res(4'd5, gold[8'hB0], "R8");
    @(posedge clk); #1;
    mem_gnt = 1'b1;
    cyc(8);

    chk(op_q.size() == 0, "R6", "memory ops left unseen", 64'(op_q.size()), 0);
    chk(res_q.size() == 0, "R10", "load results left unseen", 64'(res_q.size()), 0);
    done = 1'b1;
    report();
  end
endmodule